// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block lets a host reach the management registers of an external PHY over the two-wire MDIO bus. The host sees two 32-bit registers: a status register at offset 0 and a frame register at offset 4. Each word written to the frame register is sent on the bus as 32 bits, most significant bit first. A clock divider derives the MDC clock from the system clock. While a word is being sent, a busy flag in the status register stays set.

A full management access takes three frame-register writes, each issued once busy has cleared. The first is an all-ones preamble word. The second is the command word: start 01, a 2-bit opcode, a 5-bit PHY address, a 5-bit register address, turnaround 10, then 16 data bits. The third is an all-zeros idle word. The host builds each write command as 0x59020000 OR (register << 18) OR data, and each read command as 0x69020000 OR (register << 18). The register number is masked to 5 bits before it is shifted.

When the command word carries the read opcode, the engine releases the data line from the second turnaround bit onward. It then captures the 16 bits the PHY returns, and the host reads them from the low half of the status register.

Top module: `mdio_engine`

## Requirements
- R1: After reset, MDC is low, MDIO is released (output enable 0), the busy flag is 0, the overrun flag is 0 and the captured read data is 0.
- R2: A host write to offset 4 while busy is 0 starts a frame. Busy reads 1 from the next clock cycle and stays 1 for exactly 64*DIV_HALF system clock cycles.
- R3: MDC is low whenever busy is 0. During a frame, each MDC half period lasts DIV_HALF system clock cycles, and the frame starts with a low half, so one frame contains 32 MDC rising edges.
- R4: The frame word is sent most significant bit first, with bit 31 first. The data line changes only when MDC falls (or when a frame is loaded), so it is stable while MDC is high.
- R5: For a word whose bits 29:28 are not 10, MDIO is driven (output enable 1) for all 32 bit times.
- R6: For a word whose bits 29:28 equal 10 (the read opcode), MDIO is driven for bit times 31 down to 17 and released from bit 16 (the second turnaround bit) until the frame ends.
- R7: On a read frame, the engine samples the MDIO input on the MDC rising edges of bit times 15 down to 0, taking the first sample as the most significant bit. Status bits 15:0 then return those 16 bits. A frame that is not a read leaves them unchanged.
- R8: A write to offset 4 while busy is 1 is ignored: the frame in progress goes on unchanged. The write sets the sticky overrun flag in status bit 30.
- R9: Any host write to offset 0 clears the overrun flag.
- R10: A read at offset 0 returns busy in bit 31, overrun in bit 30, zeros in bits 29:16 and the captured data in bits 15:0. Any other offset reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | ADDR_W | Host byte offset |
| hostWData | input | 32 | Host write data |
| hostRData | output | 32 | Host read data for hostAddr |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Value driven on the data line |
| mdioOe | output | 1 | Data line output enable |
| mdioIn | input | 1 | Value observed on the data line |

## Verification
Some rules are checked by assertions on every cycle. MDC stays low while the engine is idle. The data line does not move while MDC is high. Output enable is only asserted during a frame. Busy rises only after a write to the frame register. A write during a frame sets overrun, and a status write clears it. A read sample is never taken while the engine still drives the line. Other behaviour can only be shown by the bench's scenarios: the exact frame length, the MSB-first order across a preamble, a write command and a read command, the 16 bits captured from a responding PHY model, and a frame running on unchanged after an ignored write.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;
  localparam int STAT_OFF = 0;
  localparam int GEN_OFF  = 4;
  localparam logic [1:0] OP_READ = 2'b10;
  localparam int FRAME_BITS = 32;
  localparam int DATA_BITS  = 16;

  typedef struct packed {
    logic load;    // accept a new frame word
    logic sample;  // MDC about to rise
    logic shift;   // MDC about to fall, advance to next bit
  } mdioStrb_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_eng_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       genWr,
  input  logic       statWr,
  output logic       busy,
  output logic       mdc,
  output logic       overrun,
  output logic [4:0] bitIdx,
  output mdioStrb_t  strb
);
  localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] halfCnt;
  logic halfEnd, done;

  always_comb begin
    halfEnd     = busy && (halfCnt == HALF_LAST);
    strb.load   = genWr && !busy;
    strb.sample = halfEnd && !mdc;
    strb.shift  = halfEnd && mdc && (bitIdx != 5'd0);
    done        = halfEnd && mdc && (bitIdx == 5'd0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      mdc     <= 1'b0;
      halfCnt <= '0;
      bitIdx  <= '0;
      overrun <= 1'b0;
    end else begin
      if (genWr && busy) overrun <= 1'b1;
      else if (statWr)   overrun <= 1'b0;
      if (strb.load) begin
        busy    <= 1'b1;
        mdc     <= 1'b0;
        halfCnt <= '0;
        bitIdx  <= 5'(FRAME_BITS - 1);
      end else if (halfEnd) begin
        halfCnt <= '0;
        mdc     <= !mdc;
        if (strb.shift) bitIdx <= bitIdx - 5'd1;
        if (done)       busy   <= 1'b0;
      end else if (busy) begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  // R3
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_eng_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  mdioStrb_t   strb,
  input  logic        busy,
  input  logic [4:0]  bitIdx,
  input  logic [31:0] wrData,
  input  logic        mdioIn,
  output logic        mdioOut,
  output logic        mdioOe,
  output logic [DATA_BITS-1:0] rdData
);
  logic [FRAME_BITS-1:0] shReg;
  logic isRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      isRead <= 1'b0;
      rdData <= '0;
    end else begin
      if (strb.load) begin
        shReg  <= wrData;
        isRead <= (wrData[29:28] == OP_READ);
      end else if (strb.shift) begin
        shReg <= {shReg[FRAME_BITS-2:0], 1'b0};
      end
      if (strb.sample && isRead && (bitIdx < 5'(DATA_BITS)))
        rdData <= {rdData[DATA_BITS-2:0], mdioIn};
    end
  end

  always_comb begin
    mdioOut = shReg[FRAME_BITS-1];
    mdioOe  = busy && !(isRead && (bitIdx <= 5'(DATA_BITS)));
  end

  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sample && isRead && (bitIdx < 5'(DATA_BITS))) |-> !mdioOe);
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_eng_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWData,
  output logic [31:0]       hostRData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  logic genWr, statWr, busy, overrun;
  logic [4:0] bitIdx;
  logic [DATA_BITS-1:0] rdData;
  mdioStrb_t strb;

  assign genWr  = hostWe && (hostAddr == ADDR_W'(GEN_OFF));
  assign statWr = hostWe && (hostAddr == ADDR_W'(STAT_OFF));

  mdio_ctrl #(.DIV_HALF(DIV_HALF)) uCtrl (
    .clk(clk), .rstN(rstN), .genWr(genWr), .statWr(statWr),
    .busy(busy), .mdc(mdc), .overrun(overrun), .bitIdx(bitIdx), .strb(strb)
  );

  mdio_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .bitIdx(bitIdx),
    .wrData(hostWData), .mdioIn(mdioIn), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .rdData(rdData)
  );

  assign hostRData = (hostAddr == ADDR_W'(STAT_OFF)) ?
                     {busy, overrun, 14'b0, rdData} : 32'b0;

  // R4
  mdio_stable_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && busy) |=> (!mdc || $stable(mdioOut)));
  // R5
  oe_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> busy);
  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(genWr));
  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (genWr && busy) |=> overrun);
  // R9
  overrun_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && !(genWr && busy)) |=> !overrun);
endmodule

// File: tb/tb_mdio_engine.sv
module tb_mdio_engine;
  localparam int D = 3;
  localparam int FRAME_CYC = 64 * D;

  logic clk = 0, rstN = 0, hostWe = 0, mdioIn = 1;
  logic [3:0] hostAddr = 0;
  logic [31:0] hostWData = 0, hostRData;
  logic mdc, mdioOut, mdioOe;

  mdio_engine #(.DIV_HALF(D), .ADDR_W(4)) dut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWData(hostWData), .hostRData(hostRData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #5 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  bit mBusy = 0, mOvr = 0, mRead = 0;
  int n = 0;
  logic [31:0] mWord = 0;
  logic [15:0] mRd = 0, phyData = 16'hBEEF;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mOvr = 0; mRead = 0; n = 0; mWord = 0; mRd = 0;
      mdioIn <= 1'b1;
    end else begin
      bit wasBusy, start;
      int half, bitNo;
      wasBusy = mBusy;
      start = 0;
      if (hostWe && hostAddr == 4) begin
        if (wasBusy) mOvr = 1; else start = 1;
      end else if (hostWe && hostAddr == 0) mOvr = 0;
      if (wasBusy) begin
        half = n / D;
        bitNo = 31 - half / 2;
        if ((n + 1) % D == 0 && half % 2 == 0 && mRead && bitNo <= 15)
          mRd = {mRd[14:0], mdioIn};
        n++;
        if (n == FRAME_CYC) mBusy = 0;
      end
      if (start) begin
        mBusy = 1; n = 0; mWord = hostWData;
        mRead = (hostWData[29:28] == 2'b10);
      end
      bitNo = 31 - (n / D) / 2;
      mdioIn <= (mBusy && mRead && bitNo <= 15) ? phyData[bitNo] : 1'b1;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rstN) begin
      int half, bitNo;
      bit eMdc, eOe;
      logic [31:0] eStat;
      half = n / D;
      bitNo = 31 - half / 2;
      eMdc = mBusy && (half % 2 == 1);
      eOe = mBusy && !(mRead && bitNo <= 16);
      eStat = (hostAddr == 0) ? {mBusy, mOvr, 14'b0, mRd} : 32'b0;
      chk(mdc === eMdc, "R3 mdc", {31'b0, mdc}, {31'b0, eMdc});
      chk(mdioOe === eOe, "R5/R6 oe", {31'b0, mdioOe}, {31'b0, eOe});
      if (eOe) chk(mdioOut === mWord[bitNo], "R4 data bit", {31'b0, mdioOut}, {31'b0, mWord[bitNo]});
      chk(hostRData === eStat, "R10 status R2 busy", hostRData, eStat);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    hostWe = 1; hostAddr = a; hostWData = d;
    @(posedge clk); #2;
    hostWe = 0; hostAddr = 0;
  endtask

  task automatic waitIdle();
    while (mBusy) @(posedge clk);
    #2;
  endtask

  task automatic access(input logic [31:0] cmd);
    wr(4, 32'hFFFF_FFFF); waitIdle();
    wr(4, cmd);           waitIdle();
    wr(4, 32'h0000_0000); waitIdle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(mdc === 0, "R1 mdc", {31'b0, mdc}, 0);
    chk(mdioOe === 0, "R1 oe", {31'b0, mdioOe}, 0);
    chk(hostRData === 0, "R1 status", hostRData, 0);
    rstN = 1;
    // R5 write command frame: reg 5, data A5C3
    access(32'h5902_0000 | (32'(5) << 18) | 32'hA5C3);
    chk(hostRData[15:0] === 16'h0, "R7 write leaves data", {16'b0, hostRData[15:0]}, 0);
    // R6 R7 read command frame: reg 0x1f masked
    access(32'h6902_0000 | (32'(8'h3F & 8'h1F) << 18));
    chk(hostRData[15:0] === 16'hBEEF, "R7 read data", {16'b0, hostRData[15:0]}, 32'hBEEF);
    // second read with different PHY data
    phyData = 16'h0183;
    access(32'h6902_0000 | (32'(2) << 18));
    chk(hostRData[15:0] === 16'h0183, "R7 read data 2", {16'b0, hostRData[15:0]}, 32'h0183);
    // R8 ignored write while busy
    wr(4, 32'hA5A5_5A5A);
    repeat (20) @(posedge clk);
    wr(4, 32'h1234_5678);
    #1;
    chk(hostRData[30] === 1'b1, "R8 overrun set", hostRData, 32'hC000_0000);
    waitIdle();
    chk(hostRData[31:30] === 2'b01, "R8 frame ran unchanged", {30'b0, hostRData[31:30]}, 1);
    // R9 clear overrun
    wr(0, 32'h0);
    #1;
    chk(hostRData[30] === 1'b0, "R9 overrun cleared", hostRData, 0);
    // R10 other offset reads zero
    hostAddr = 4; #1;
    chk(hostRData === 0, "R10 other offset", hostRData, 0);
    hostAddr = 0;
    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule